// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries a single word from a writer clock domain to a reader clock domain without passing through a queue. A writer stores a word by asserting its select and write strobe on a writer clock edge while the mailbox is open. The store locks the mailbox and pulls the writer-side idle flag low. The reader learns of the pending word through its own valid flag and takes it with a select-qualified read strobe. The take travels back to the writer domain and reopens the mailbox. The reader output port is shared with a queue's output register: the reader select steers either the mailbox word or the queue word onto it.

Each crossing is carried by a level toggle through a two-flop synchronizer, so no store and no take can be lost whatever the ratio of the two clocks. The writer controller has two states. WS_OPEN moves to WS_LOCKED on an accepted store. WS_LOCKED moves back to WS_OPEN when the synchronized take toggle equals the store toggle. The reader controller also has two states. RS_EMPTY moves to RS_HOLD when the synchronized store toggle differs from the local take toggle. RS_HOLD moves back to RS_EMPTY on a take. A narrow-bus configuration input keeps only the low half of the word, to match a port configured for half width.

Top module: `xdom_mailbox`

## Requirements
- R1: A store is a writer clock edge with `wr_sel`=1, `wr_en`=1 and `mail_idle`=1. It captures `wr_data`, and `mail_idle` is 0 after that edge.
- R2: While `mail_idle` is 0, further writer strobes are ignored and the stored word does not change.
- R3: `rd_mail_valid` rises within 4 reader clock edges after a store. A take is a reader edge with `rd_sel`=1, `rd_en`=1 and `rd_mail_valid`=1, and `rd_mail_valid` is 0 after that edge.
- R4: After a take, `mail_idle` returns to 1 within 4 writer clock edges. Without a take it stays 0 indefinitely.
- R5: `rd_data` equals the stored word when `rd_sel`=1 and equals `fifo_data` when `rd_sel`=0. It follows `rd_sel` combinationally.
- R6: A strobe without its select has no effect: `wr_en` with `wr_sel`=0, or `rd_en` with `rd_sel`=0. A read strobe while `rd_mail_valid`=0 also has no effect and does not release a later store.
- R7: With `narrow_mode`=1, only bits [DATA_W/2-1:0] are stored and the upper bits read as 0. With `narrow_mode`=0, the full width is stored. `narrow_mode` only changes while both resets are asserted.
- R8: With both resets asserted together (active low), `mail_idle`=1, `rd_mail_valid`=0 and the stored word is 0. A pending word is discarded.
- R9: `rd_mail_valid` is 1 only while `mail_idle` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Writer domain clock |
| wr_rst_n | input | 1 | Writer domain asynchronous reset, active low |
| wr_sel | input | 1 | Writer addresses the mailbox |
| wr_en | input | 1 | Writer strobe |
| wr_data | input | DATA_W | Word to store |
| narrow_mode | input | 1 | 1 keeps only the low half of the word |
| mail_idle | output | 1 | 1 when the mailbox is open, 0 while a word is pending |
| rd_clk | input | 1 | Reader domain clock |
| rd_rst_n | input | 1 | Reader domain asynchronous reset, active low |
| rd_sel | input | 1 | Reader addresses the mailbox instead of the queue |
| rd_en | input | 1 | Reader strobe |
| fifo_data | input | DATA_W | Queue output-register word |
| rd_data | output | DATA_W | Reader port data |
| rd_mail_valid | output | 1 | Reader domain flag for a pending word |

## Verification
The assertions check these properties on every cycle:
- a store closes the mailbox;
- the stored word is frozen while the mailbox is closed;
- a take drops the reader flag;
- the reader never shows a pending word while the writer side is open;
- the upper half reads zero in narrow mode.

The crossing latencies are bounded only by the bench's scenarios, which use unrelated writer and reader clock periods. The same holds for the refusal of strobes without select, the empty-read case that must not release a later store, and the discard on reset. The bench sweeps a set of computed data patterns through full store-and-take handshakes, in both full and narrow mode.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

    typedef enum logic {
        WS_OPEN   = 1'b0,
        WS_LOCKED = 1'b1
    } wr_state_e;

    typedef enum logic {
        RS_EMPTY = 1'b0,
        RS_HOLD  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/mbx_sync.sv
`timescale 1ns/1ps
module mbx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[TOP-1:0], d};
            end
        end
    endgenerate

    assign q = chain_q[TOP];

endmodule

// File: rtl/mbx_wr_ctrl.sv
`timescale 1ns/1ps
module mbx_wr_ctrl
    import mbx_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              en,
    input  logic              narrow,
    input  logic [DATA_W-1:0] data,
    input  logic              ack_tog,
    output logic              req_tog,
    output logic [DATA_W-1:0] mbox,
    output logic              idle
);

    localparam int LOW_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LOW_MASK = {{(DATA_W-LOW_W){1'b0}}, {LOW_W{1'b1}}};

    wr_state_e         st_q, st_d;
    logic              tog_q;
    logic [DATA_W-1:0] mbox_q;
    logic              accept;

    assign accept = sel & en & (st_q == WS_OPEN);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WS_OPEN;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WS_OPEN:   if (accept)            st_d = WS_LOCKED;
            WS_LOCKED: if (ack_tog == tog_q)  st_d = WS_OPEN;
            default:                          st_d = WS_OPEN;
        endcase
    end

    // store path: toggle and word move only on an accepted store
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tog_q  <= 1'b0;
            mbox_q <= '0;
        end else if (accept) begin
            tog_q  <= ~tog_q;
            mbox_q <= narrow ? (data & LOW_MASK) : data;
        end
    end

    // outputs
    always_comb begin
        idle    = (st_q == WS_OPEN);
        req_tog = tog_q;
        mbox    = mbox_q;
    end

endmodule

// File: rtl/mbx_rd_ctrl.sv
`timescale 1ns/1ps
module mbx_rd_ctrl
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic en,
    input  logic req_tog,
    output logic ack_tog,
    output logic valid
);

    rd_state_e st_q, st_d;
    logic      tog_q;
    logic      take;

    assign take = sel & en & (st_q == RS_HOLD);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RS_EMPTY;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RS_EMPTY: if (req_tog != tog_q) st_d = RS_HOLD;
            RS_HOLD:  if (take)             st_d = RS_EMPTY;
            default:                        st_d = RS_EMPTY;
        endcase
    end

    // take toggle: flips only on a take, which re-aligns it with the store toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    tog_q <= 1'b0;
        else if (take) tog_q <= ~tog_q;
    end

    // outputs
    always_comb begin
        valid   = (st_q == RS_HOLD);
        ack_tog = tog_q;
    end

endmodule

// File: rtl/xdom_mailbox.sv
`timescale 1ns/1ps
module xdom_mailbox #(
    parameter int DATA_W      = 18,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              wr_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              narrow_mode,
    output logic              mail_idle,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              rd_sel,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] fifo_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_mail_valid
);

    logic              req_tog;
    logic              req_tog_rd;
    logic              ack_tog;
    logic              ack_tog_wr;
    logic [DATA_W-1:0] mbox_q;

    mbx_wr_ctrl #(.DATA_W(DATA_W)) u_wr (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .sel     (wr_sel),
        .en      (wr_en),
        .narrow  (narrow_mode),
        .data    (wr_data),
        .ack_tog (ack_tog_wr),
        .req_tog (req_tog),
        .mbox    (mbox_q),
        .idle    (mail_idle)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .d     (req_tog),
        .q     (req_tog_rd)
    );

    mbx_rd_ctrl u_rd (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .sel     (rd_sel),
        .en      (rd_en),
        .req_tog (req_tog_rd),
        .ack_tog (ack_tog),
        .valid   (rd_mail_valid)
    );

    mbx_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .d     (ack_tog),
        .q     (ack_tog_wr)
    );

    // the word is frozen while pending, so the reader may sample it directly
    assign rd_data = rd_sel ? mbox_q : fifo_data;

endmodule

// File: rtl/mbx_checker.sv
`timescale 1ns/1ps
module mbx_checker #(
    parameter int DATA_W = 18
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              wr_sel,
    input logic              wr_en,
    input logic              mail_idle,
    input logic [DATA_W-1:0] mbox_q,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              rd_sel,
    input logic              rd_en,
    input logic              rd_mail_valid,
    input logic [DATA_W-1:0] rd_data,
    input logic              narrow_mode
);

    localparam int LOW_W = DATA_W / 2;

    AST_STORE_CLOSES: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (wr_sel && wr_en && mail_idle) |=> !mail_idle); // R1

    AST_LOCKED_WORD_STABLE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        !mail_idle |=> $stable(mbox_q)); // R2

    AST_TAKE_DROPS_VALID: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_sel && rd_en && rd_mail_valid) |=> !rd_mail_valid); // R3

    AST_NARROW_UPPER_ZERO: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (narrow_mode && rd_sel) |-> (rd_data[DATA_W-1:LOW_W] == '0)); // R7

    AST_RESET_OPENS: assert property (@(posedge wr_clk)
        !wr_rst_n |=> mail_idle); // R8

    AST_VALID_ONLY_LOCKED: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || !wr_rst_n)
        rd_mail_valid |-> !mail_idle); // R9

endmodule

bind xdom_mailbox mbx_checker #(.DATA_W(DATA_W)) u_chk (
    .wr_clk        (wr_clk),
    .wr_rst_n      (wr_rst_n),
    .wr_sel        (wr_sel),
    .wr_en         (wr_en),
    .mail_idle     (mail_idle),
    .mbox_q        (mbox_q),
    .rd_clk        (rd_clk),
    .rd_rst_n      (rd_rst_n),
    .rd_sel        (rd_sel),
    .rd_en         (rd_en),
    .rd_mail_valid (rd_mail_valid),
    .rd_data       (rd_data),
    .narrow_mode   (narrow_mode)
);

// File: tb/sim_xdom_mailbox.sv
`timescale 1ns/1ps
module sim_xdom_mailbox;

    localparam int W = 18;
    localparam int H = W / 2;

    logic         wr_clk = 1'b0;
    logic         rd_clk = 1'b0;
    logic         wr_rst_n = 1'b0;
    logic         rd_rst_n = 1'b0;
    logic         wr_sel = 1'b0;
    logic         wr_en = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic         narrow_mode = 1'b0;
    logic         rd_sel = 1'b0;
    logic         rd_en = 1'b0;
    logic [W-1:0] fifo_data = '0;
    logic         mail_idle;
    logic         rd_mail_valid;
    logic [W-1:0] rd_data;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    xdom_mailbox #(.DATA_W(W), .SYNC_STAGES(2)) u0 (
        .wr_clk        (wr_clk),
        .wr_rst_n      (wr_rst_n),
        .wr_sel        (wr_sel),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .narrow_mode   (narrow_mode),
        .mail_idle     (mail_idle),
        .rd_clk        (rd_clk),
        .rd_rst_n      (rd_rst_n),
        .rd_sel        (rd_sel),
        .rd_en         (rd_en),
        .fifo_data     (fifo_data),
        .rd_data       (rd_data),
        .rd_mail_valid (rd_mail_valid)
    );

    always #2 wr_clk = ~wr_clk;               // 250 MHz writer clock
    initial begin                              // unrelated reader clock, 7 ns
        #1.5;
        forever begin
            rd_clk = ~rd_clk;
            #3.5;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_put(input logic [W-1:0] d, input bit sel, input bit en);
        @(negedge wr_clk);
        wr_sel = sel; wr_en = en; wr_data = d;
        @(negedge wr_clk);
        wr_sel = 1'b0; wr_en = 1'b0;
    endtask

    task automatic rd_strobe(input bit sel, input bit en);
        @(negedge rd_clk);
        rd_sel = sel; rd_en = en;
        @(negedge rd_clk);
        rd_sel = 1'b0; rd_en = 1'b0;
    endtask

    task automatic wait_valid(output int n);
        n = 0;
        while (!rd_mail_valid && n < 10) begin
            @(negedge rd_clk);
            n++;
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (!mail_idle && n < 10) begin
            @(negedge wr_clk);
            n++;
        end
    endtask

    task automatic apply_reset(input bit narrow);
        @(negedge wr_clk);
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        narrow_mode = narrow;
        repeat (4) @(negedge wr_clk);
        rd_sel = 1'b1; #0.5;
        chk(mail_idle == 1'b1, "R8 idle in reset", 32'(mail_idle), 1);
        chk(rd_mail_valid == 1'b0, "R8 valid in reset", 32'(rd_mail_valid), 0);
        chk(rd_data == '0, "R8 word cleared", 32'(rd_data), 0);
        rd_sel = 1'b0;
        @(negedge wr_clk);
        wr_rst_n = 1'b1; rd_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
    endtask

    // full handshake for one word
    task automatic run_one(input logic [W-1:0] d, input logic [W-1:0] q);
        logic [W-1:0] exp;
        int n;
        exp = narrow_mode ? {{(W-H){1'b0}}, d[H-1:0]} : d;
        wr_put(d, 1'b1, 1'b1);
        chk(mail_idle == 1'b0, "R1 store closes", 32'(mail_idle), 0);
        wr_put(~d, 1'b1, 1'b1);
        chk(mail_idle == 1'b0, "R2 still closed", 32'(mail_idle), 0);
        wait_valid(n);
        chk(rd_mail_valid && n <= 4, "R3 valid latency", 32'(n), 4);
        @(negedge rd_clk);
        rd_sel = 1'b1; #0.5;
        chk(rd_data == exp, "R2 R5 R7 word read", 32'(rd_data), 32'(exp));
        fifo_data = q; rd_sel = 1'b0; #0.5;
        chk(rd_data == q, "R5 queue selected", 32'(rd_data), 32'(q));
        rd_strobe(1'b0, 1'b1);
        chk(rd_mail_valid == 1'b1, "R6 read without select", 32'(rd_mail_valid), 1);
        rd_strobe(1'b1, 1'b1);
        chk(rd_mail_valid == 1'b0, "R3 take drops valid", 32'(rd_mail_valid), 0);
        wait_idle(n);
        chk(mail_idle && n <= 4, "R4 reopen latency", 32'(n), 4);
    endtask

    initial begin
        int n;
        apply_reset(1'b0);

        // writer strobe without select, and select without strobe
        wr_put(18'h2AAAA, 1'b0, 1'b1);
        chk(mail_idle == 1'b1, "R6 write without select", 32'(mail_idle), 1);
        wr_put(18'h15555, 1'b1, 1'b0);
        chk(mail_idle == 1'b1, "R6 select without strobe", 32'(mail_idle), 1);
        repeat (5) @(negedge rd_clk);
        chk(rd_mail_valid == 1'b0, "R6 no mail seen", 32'(rd_mail_valid), 0);

        // empty read must not release a later store
        rd_strobe(1'b1, 1'b1);
        wr_put(18'h0BEEF, 1'b1, 1'b1);
        repeat (14) @(negedge wr_clk);
        chk(mail_idle == 1'b0, "R4 R6 held without take", 32'(mail_idle), 0);
        wait_valid(n);
        rd_strobe(1'b1, 1'b1);
        wait_idle(n);
        chk(mail_idle == 1'b1, "R4 reopen after take", 32'(mail_idle), 1);

        // boundary patterns then a computed sweep, full width
        run_one('0, '1);
        run_one('1, '0);
        for (int i = 0; i < 40; i++) begin
            logic [31:0] t;
            logic [31:0] u;
            t = (i + 1) * 32'h9E3779B1;
            u = t ^ 32'h5A5A5A5A;
            run_one(t[W-1:0], u[W+3:4]);
        end

        // discard of a pending word by reset
        wr_put(18'h3C3C3, 1'b1, 1'b1);
        wait_valid(n);
        chk(rd_mail_valid == 1'b1, "R3 pending before reset", 32'(rd_mail_valid), 1);
        apply_reset(1'b1);
        repeat (6) @(negedge rd_clk);
        chk(rd_mail_valid == 1'b0 && mail_idle == 1'b1, "R8 pending discarded",
            32'({rd_mail_valid, mail_idle}), 1);

        // narrow configuration sweep
        run_one('1, 18'h12345);
        for (int i = 0; i < 24; i++) begin
            logic [31:0] t;
            t = (i + 7) * 32'h85EBCA6B;
            run_one(t[W+1:2], t[W-1:0]);
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge wr_clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule